// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of complete address translations, from guest-virtual page to host-physical page. An external page walker resolves each translation and writes it in, and the core looks translations up. Every entry carries an address-space tag. Translations that belong to different guests, and to the host, can therefore sit side by side. Switching the active context changes only the tag that the core presents with each lookup, and nothing is flushed.

Entries map 4 KB, 2 MB or 1 GB pages. When an entry maps a large page, the comparison ignores the low virtual page bits that fall inside that page, and the returned physical page number takes those low bits from the lookup address. Three invalidate commands are offered. The first clears everything. The second clears every entry of one address space. The third clears the entries of one address space whose page covers a given address. Tag 0 is kept for the host by convention and behaves like any other tag.

Top module: `asid_tlb`

## Requirements
- R1: Each cycle with `lk_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. A cycle without a request produces no response.
- R2: A response hits only when a valid entry has the same tag as `lk_asid` and the same page as `lk_vpn` under that entry's size mask. A hit returns the entry's permissions and size. A miss returns `rsp_hit`, `rsp_ppn`, `rsp_perm` and `rsp_size` all zero.
- R3: Lookups under a different tag neither hit nor disturb the entries of another tag. Without an invalidate command, the number of valid entries never drops.
- R4: The size code is 0 for 4 KB, 1 for 2 MB, 2 for 1 GB, and 3 is stored as 4 KB. A 2 MB entry ignores the low 9 virtual page bits and a 1 GB entry ignores the low 18. The low bits of the returned physical page are taken from `lk_vpn`.
- R5: A fill that matches no entry is written to the lowest-numbered invalid entry.
- R6: A fill with the same tag, the same size and the same masked page as a valid entry overwrites that entry. It creates no second copy and causes no eviction.
- R7: When every entry is valid and a fill matches none of them, the fill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one only on such replacements.
- R8: Invalidate code 0 clears every entry.
- R9: Invalidate code 1 clears exactly the entries whose tag equals `inv_asid`.
- R10: Invalidate code 2 clears the entries whose tag equals `inv_asid` and whose page covers `inv_vpn` under that entry's own size mask. Code 3 changes nothing.
- R11: When an invalidate and a fill arrive in the same cycle, the invalidate takes effect and the fill is dropped.
- R12: A lookup in the same cycle as a fill sees the contents from before that fill.
- R13: After reset no entry is valid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Tag of the current address space |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_hit | output | 1 | Translation found |
| rsp_ppn | output | PPN_W | Physical page number, low bits merged for large pages |
| rsp_perm | output | PERM_W | Permissions of the hit entry |
| rsp_size | output | 2 | Size code of the hit entry |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_asid | input | ASID_W | Tag of the fill |
| fill_size | input | 2 | Size code of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_perm | input | PERM_W | Permissions of the fill |
| inv_valid | input | 1 | Invalidate command |
| inv_kind | input | 2 | 0 all, 1 by tag, 2 by tag and address, 3 none |
| inv_asid | input | ASID_W | Tag for codes 1 and 2 |
| inv_vpn | input | VPN_W | Address for code 2 |

## Verification
Some properties are checked on every cycle. These are the one-cycle request-to-response pairing, the rule that a hit needs a response, and the rule that the valid count never falls without an invalidate, which is what makes a context switch cheap. They also cover the complete clear after invalidate-all, invalidate winning over a same-cycle fill, eviction happening only when the array is full, and the single allocation slot per fill. Other behaviour only shows up through the bench's scenarios. That includes which entry a replacement removes, that a refill of a present page keeps the pointer still, how the low address bits merge for 2 MB and 1 GB pages, and that an address-specific invalidate spares other tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_TAG  = 2'd1,
    INV_ADDR = 2'd2,
    INV_NOP  = 2'd3
  } inv_kind_e;

  localparam int unsigned LVL_BITS = 9;

  // Reserved size code behaves as the smallest page.
  function automatic logic [1:0] size_norm(logic [1:0] s);
    return (s == PG_RSV) ? PG_4K : s;
  endfunction

  // Number of low virtual page bits that lie inside a page of this size.
  function automatic int unsigned size_shift(logic [1:0] s);
    case (s)
      PG_2M:   return LVL_BITS;
      PG_1G:   return 2 * LVL_BITS;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] low_ones(int unsigned n);
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q,
  input  logic [ENTRIES-1:0][1:0]        size_q,
  input  logic [VPN_W-1:0]               lk_vpn,
  input  logic [ASID_W-1:0]              lk_asid,
  input  logic [VPN_W-1:0]               fill_vpn,
  input  logic [ASID_W-1:0]              fill_asid,
  input  logic [1:0]                     fill_size,
  input  logic                           inv_valid,
  input  logic [1:0]                     inv_kind,
  input  logic [ASID_W-1:0]              inv_asid,
  input  logic [VPN_W-1:0]               inv_vpn,
  output logic [ENTRIES-1:0]             lk_hit_vec,
  output logic [ENTRIES-1:0]             fill_hit_vec,
  output logic [ENTRIES-1:0]             inv_clr_vec
);
  function automatic logic page_eq(logic [VPN_W-1:0] a, logic [VPN_W-1:0] b,
                                   logic [1:0] s);
    logic [VPN_W-1:0] keep;
    keep = ~VPN_W'(low_ones(size_shift(s)));
    return ((a ^ b) & keep) == '0;
  endfunction

  logic [1:0] fill_sz_n;
  assign fill_sz_n = size_norm(fill_size);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic tag_lk, tag_fill, tag_inv, addr_inv, clr_sel;
    assign tag_lk   = asid_q[g] == lk_asid;
    assign tag_fill = asid_q[g] == fill_asid;
    assign tag_inv  = asid_q[g] == inv_asid;
    assign addr_inv = page_eq(vpn_q[g], inv_vpn, size_q[g]);

    always_comb begin
      case (inv_kind)
        INV_ALL:  clr_sel = 1'b1;
        INV_TAG:  clr_sel = tag_inv;
        INV_ADDR: clr_sel = tag_inv && addr_inv;
        default:  clr_sel = 1'b0;
      endcase
    end

    assign lk_hit_vec[g]   = valid_q[g] && tag_lk && page_eq(vpn_q[g], lk_vpn, size_q[g]);
    assign fill_hit_vec[g] = valid_q[g] && tag_fill && (size_q[g] == fill_sz_n)
                             && page_eq(vpn_q[g], fill_vpn, fill_sz_n);
    assign inv_clr_vec[g]  = inv_valid && valid_q[g] && clr_sel;
  end
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
  parameter int ENTRIES = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] fill_hit_vec,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [IW-1:0]      rr_ptr,
  output logic [IW-1:0]      alloc_idx,
  output logic               need_evict,
  output logic [ENTRIES-1:0] alloc_onehot
);
  logic          match_any, free_any;
  logic [IW-1:0] match_idx, free_idx;

  tlb_first #(.N(ENTRIES)) u_match (.vec(fill_hit_vec), .any(match_any), .idx(match_idx));
  tlb_first #(.N(ENTRIES)) u_free  (.vec(~valid_q),     .any(free_any),  .idx(free_idx));

  always_comb begin
    if (match_any)     alloc_idx = match_idx;
    else if (free_any) alloc_idx = free_idx;
    else               alloc_idx = rr_ptr;
  end

  assign need_evict   = !match_any && !free_any;
  assign alloc_onehot = ENTRIES'(1) << alloc_idx;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28,
  parameter int ASID_W  = 8,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic [1:0]        rsp_size,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [1:0]        fill_size,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_kind,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry storage
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][1:0]        size_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic [IW-1:0]                  rr_q;

  // Named internal events
  logic [ENTRIES-1:0] lk_hit_vec, fill_hit_vec, inv_clr_vec, alloc_onehot;
  logic               lk_any, need_evict, fill_do, evict_do;
  logic [IW-1:0]      lk_idx, alloc_idx;
  logic [1:0]         fill_sz_n;
  logic [VPN_W-1:0]   fill_vpn_m;
  logic [PPN_W-1:0]   lk_ppn;

  function automatic logic [PPN_W-1:0] merge_ppn(logic [PPN_W-1:0] base,
                                                 logic [VPN_W-1:0] va,
                                                 logic [1:0] s);
    logic [PPN_W-1:0] m;
    m = PPN_W'(low_ones(size_shift(s)));
    return (base & ~m) | (PPN_W'(va) & m);
  endfunction

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .valid_q(valid_q), .asid_q(asid_q), .vpn_q(vpn_q), .size_q(size_q),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_size(fill_size),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid), .inv_vpn(inv_vpn),
    .lk_hit_vec(lk_hit_vec), .fill_hit_vec(fill_hit_vec), .inv_clr_vec(inv_clr_vec)
  );

  tlb_first #(.N(ENTRIES)) u_lk_sel (.vec(lk_hit_vec), .any(lk_any), .idx(lk_idx));

  tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .fill_hit_vec(fill_hit_vec), .valid_q(valid_q), .rr_ptr(rr_q),
    .alloc_idx(alloc_idx), .need_evict(need_evict), .alloc_onehot(alloc_onehot)
  );

  assign fill_do    = fill_valid && !inv_valid;
  assign evict_do   = fill_do && need_evict;
  assign fill_sz_n  = size_norm(fill_size);
  assign fill_vpn_m = fill_vpn & ~VPN_W'(low_ones(size_shift(fill_sz_n)));
  assign lk_ppn     = merge_ppn(ppn_q[lk_idx], lk_vpn, size_q[lk_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= (valid_q & ~inv_clr_vec) | (fill_do ? alloc_onehot : '0);
      if (evict_do) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      asid_q[alloc_idx] <= fill_asid;
      vpn_q[alloc_idx]  <= fill_vpn_m;
      size_q[alloc_idx] <= fill_sz_n;
      ppn_q[alloc_idx]  <= fill_ppn;
      perm_q[alloc_idx] <= fill_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any;
      rsp_ppn   <= (lk_valid && lk_any) ? lk_ppn : '0;
      rsp_perm  <= (lk_valid && lk_any) ? perm_q[lk_idx] : '0;
      rsp_size  <= (lk_valid && lk_any) ? size_q[lk_idx] : '0;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               inv_valid,
  input logic [1:0]         inv_kind,
  input logic [ENTRIES-1:0] valid_q,
  input logic               fill_do,
  input logic               evict_do,
  input logic [ENTRIES-1:0] alloc_onehot
);
  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  assert_hit_has_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_no_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid |=> $countones(valid_q) >= $past($countones(valid_q)));

  assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |-> $countones(alloc_onehot) == 1);

  assert_evict_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_do |-> (&valid_q));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'd0) |=> valid_q == '0);

  assert_inv_beats_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !fill_do);
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .inv_valid(inv_valid), .inv_kind(inv_kind),
  .valid_q(valid_q), .fill_do(fill_do), .evict_do(evict_do),
  .alloc_onehot(alloc_onehot)
);

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
  localparam int VW = 36;
  localparam int PW = 28;
  localparam int AW = 8;
  localparam int MW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          rsp_valid, rsp_hit;
  logic [PW-1:0] rsp_ppn;
  logic [MW-1:0] rsp_perm;
  logic [1:0]    rsp_size;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [AW-1:0] fill_asid = '0;
  logic [1:0]    fill_size = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [MW-1:0] fill_perm = '0;
  logic          inv_valid = 1'b0;
  logic [1:0]    inv_kind = '0;
  logic [AW-1:0] inv_asid = '0;
  logic [VW-1:0] inv_vpn = '0;

  always #2.5 clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_perm(rsp_perm), .rsp_size(rsp_size),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_size(fill_size), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid), .inv_vpn(inv_vpn)
  );

  typedef struct packed {
    logic          hit;
    logic [PW-1:0] ppn;
    logic [MW-1:0] perm;
    logic [1:0]    size;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // Physical page as the requirement describes it: the bits inside the page
  // come from the lookup address.
  function automatic logic [PW-1:0] want_ppn(logic [PW-1:0] base, logic [VW-1:0] va,
                                             logic [1:0] sz);
    case (sz)
      2'd1:    return {base[PW-1:9], va[8:0]};
      2'd2:    return {base[PW-1:18], va[17:0]};
      default: return base;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Driver: queue the expected response and raise one lookup.
  task automatic look(input logic [VW-1:0] va, input logic [AW-1:0] as,
                      input bit hit, input logic [PW-1:0] pa,
                      input logic [MW-1:0] pm, input logic [1:0] sz,
                      input string tag);
    exp_t e;
    @(negedge clk);
    e.hit = hit;
    e.ppn = hit ? pa : '0;
    e.perm = hit ? pm : '0;
    e.size = hit ? sz : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    lk_valid = 1'b1; lk_vpn = va; lk_asid = as;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic put(input logic [VW-1:0] va, input logic [AW-1:0] as,
                     input logic [1:0] sz, input logic [PW-1:0] pa,
                     input logic [MW-1:0] pm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = va; fill_asid = as;
    fill_size = sz; fill_ppn = pa; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic kill(input logic [1:0] k, input logic [AW-1:0] as,
                      input logic [VW-1:0] va);
    @(negedge clk);
    inv_valid = 1'b1; inv_kind = k; inv_asid = as; inv_vpn = va;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  // Monitor: compare every response against the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "response with no request pending");
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_hit, rsp_ppn, rsp_perm, rsp_size} == e, t,
              $sformatf("actual hit=%0b ppn=%h perm=%h size=%0d expected hit=%0b ppn=%h perm=%h size=%0d",
                        rsp_hit, rsp_ppn, rsp_perm, rsp_size, e.hit, e.ppn, e.perm, e.size));
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R13",
          $sformatf("actual valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit));
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", $sformatf("actual rsp_valid=%0b expected 0", rsp_valid));
    look(36'h12345, 8'd1, 0, 0, 0, 0, "R13");

    // R2 / R3: tagged hits and misses
    put(36'h12345, 8'd1, 2'd0, 28'hABC, 4'h5);
    look(36'h12345, 8'd1, 1, 28'hABC, 4'h5, 2'd0, "R2");
    look(36'h12345, 8'd2, 0, 0, 0, 0, "R3");
    look(36'h12346, 8'd1, 0, 0, 0, 0, "R2");
    put(36'h12345, 8'd2, 2'd0, 28'hDEF, 4'h3);
    put(36'h12345, 8'd0, 2'd0, 28'h111, 4'hF);
    look(36'h12345, 8'd1, 1, 28'hABC, 4'h5, 2'd0, "R3");
    look(36'h12345, 8'd2, 1, 28'hDEF, 4'h3, 2'd0, "R3");
    look(36'h12345, 8'd0, 1, 28'h111, 4'hF, 2'd0, "R3");

    // R4: large pages
    put(36'h00400, 8'd3, 2'd1, 28'h2000, 4'h1);
    put(36'h80000, 8'd3, 2'd2, 28'h100000, 4'h2);
    look(36'h004AB, 8'd3, 1, want_ppn(28'h2000, 36'h004AB, 2'd1), 4'h1, 2'd1, "R4");
    look(36'h00600, 8'd3, 0, 0, 0, 0, "R4");
    look(36'h83ABC, 8'd3, 1, want_ppn(28'h100000, 36'h83ABC, 2'd2), 4'h2, 2'd2, "R4");
    put(36'h00777, 8'd9, 2'd3, 28'h0042, 4'h6);
    look(36'h00777, 8'd9, 1, 28'h0042, 4'h6, 2'd0, "R4");
    look(36'h00776, 8'd9, 0, 0, 0, 0, "R4");

    // R6: refill of a present page overwrites it
    put(36'h12345, 8'd1, 2'd0, 28'h777, 4'h1);
    look(36'h12345, 8'd1, 1, 28'h777, 4'h1, 2'd0, "R6");

    // R9: clear one tag
    kill(2'd1, 8'd3, '0);
    look(36'h004AB, 8'd3, 0, 0, 0, 0, "R9");
    look(36'h83ABC, 8'd3, 0, 0, 0, 0, "R9");
    look(36'h12345, 8'd1, 1, 28'h777, 4'h1, 2'd0, "R9");

    // R10: clear by tag and address, and the no-op code
    put(36'h20000, 8'd1, 2'd0, 28'h55, 4'h2);
    kill(2'd2, 8'd1, 36'h12345);
    look(36'h12345, 8'd1, 0, 0, 0, 0, "R10");
    look(36'h12345, 8'd2, 1, 28'hDEF, 4'h3, 2'd0, "R10");
    look(36'h20000, 8'd1, 1, 28'h55, 4'h2, 2'd0, "R10");
    put(36'h00800, 8'd4, 2'd1, 28'h3000, 4'h4);
    kill(2'd2, 8'd4, 36'h008C5);
    look(36'h00800, 8'd4, 0, 0, 0, 0, "R10");
    kill(2'd3, 8'd2, 36'h12345);
    look(36'h12345, 8'd2, 1, 28'hDEF, 4'h3, 2'd0, "R10");

    // R11: invalidate and fill together
    @(negedge clk);
    inv_valid = 1'b1; inv_kind = 2'd1; inv_asid = 8'd2;
    fill_valid = 1'b1; fill_vpn = 36'h999; fill_asid = 8'd5;
    fill_size = 2'd0; fill_ppn = 28'h9; fill_perm = 4'h9;
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    look(36'h00999, 8'd5, 0, 0, 0, 0, "R11");
    look(36'h12345, 8'd2, 0, 0, 0, 0, "R11");

    // R12: lookup alongside a fill sees the old contents
    @(negedge clk);
    exp_q.push_back('0);
    tag_q.push_back("R12");
    lk_valid = 1'b1; lk_vpn = 36'h50; lk_asid = 8'd6;
    fill_valid = 1'b1; fill_vpn = 36'h50; fill_asid = 8'd6;
    fill_size = 2'd0; fill_ppn = 28'h66; fill_perm = 4'h7;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    look(36'h50, 8'd6, 1, 28'h66, 4'h7, 2'd0, "R12");

    // R8: clear everything
    kill(2'd0, '0, '0);
    look(36'h20000, 8'd1, 0, 0, 0, 0, "R8");
    look(36'h12345, 8'd0, 0, 0, 0, 0, "R8");
    look(36'h50, 8'd6, 0, 0, 0, 0, "R8");

    // R5 / R7: fill all slots, then replace round robin
    for (int i = 0; i < 16; i++) put(36'h1000 + i, 8'd7, 2'd0, 28'h100 + i, 4'h3);
    for (int i = 0; i < 16; i++) look(36'h1000 + i, 8'd7, 1, 28'h100 + i, 4'h3, 2'd0, "R5");
    put(36'h2000, 8'd7, 2'd0, 28'h200, 4'h3);
    look(36'h1000, 8'd7, 0, 0, 0, 0, "R7");
    look(36'h1001, 8'd7, 1, 28'h101, 4'h3, 2'd0, "R7");
    look(36'h2000, 8'd7, 1, 28'h200, 4'h3, 2'd0, "R7");
    put(36'h2001, 8'd7, 2'd0, 28'h201, 4'h3);
    look(36'h1001, 8'd7, 0, 0, 0, 0, "R7");
    // R6: refill in a full array evicts nothing and keeps the pointer
    put(36'h1005, 8'd7, 2'd0, 28'h305, 4'h3);
    for (int i = 2; i < 16; i++)
      look(36'h1000 + i, 8'd7, 1, (i == 5) ? 28'h305 : 28'h100 + i, 4'h3, 2'd0, "R6");
    put(36'h2002, 8'd7, 2'd0, 28'h202, 4'h3);
    look(36'h1002, 8'd7, 0, 0, 0, 0, "R7");
    look(36'h1003, 8'd7, 1, 28'h103, 4'h3, 2'd0, "R7");
    // R5: a freed middle slot is reused before any eviction
    kill(2'd2, 8'd7, 36'h1007);
    put(36'h3000, 8'd7, 2'd0, 28'h300, 4'h3);
    look(36'h1003, 8'd7, 1, 28'h103, 4'h3, 2'd0, "R5");
    look(36'h3000, 8'd7, 1, 28'h300, 4'h3, 2'd0, "R5");
    look(36'h1007, 8'd7, 0, 0, 0, 0, "R5");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1",
          $sformatf("actual %0d responses missing expected 0", exp_q.size()));
    done = 1'b1;
    finish_run();
  end
endmodule